// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is a board-test controller for a device whose I/O cells can be programmed. A tester drives it through four serial signals: a test clock, a mode select, serial data in and serial data out. There is no dedicated test reset pin. The controller walks the standard sixteen-state test-access state machine. Around that machine sit a 3-bit instruction register, a one-bit bypass register and a boundary register that holds three bits for each of a parameterised number of I/O cells.

Three instructions are recognised. In the bypass instruction the device adds one clock of delay to the scan chain. In the sample/preload instruction the boundary register captures the pins and core signals without changing how the pins behave, and values can be loaded ahead of a later external test. In the external-test instruction the boundary update register drives every pin's data and enable. A device-wide output-disable request normally turns off every pin driver. While the external test runs, the controller ignores that request.

A synchronous power-on reset returns the controller to its reset state. Once running, holding the mode select high for five test clocks does the same.

Top module: `scanTapTop`

## Requirements
- R1: From any state, five consecutive rising test-clock edges with mode select high leave the controller in Test-Logic-Reset, with the serial output disabled and bypass selected.
- R2: Power-on reset, sampled on a rising test-clock edge, forces Test-Logic-Reset; afterwards the serial output is disabled and the pins follow the core.
- R3: While in Test-Logic-Reset the instruction becomes BYPASS (3'b111). Every opcode other than 3'b000 and 3'b010 behaves as BYPASS.
- R4: In Capture-IR the instruction shift register loads 3'b001, and the least significant bit is shifted out first.
- R5: A new instruction takes effect only on the falling edge in Update-IR. While it is being shifted, the old instruction keeps control of the pins.
- R6: The serial output enable is high only in Shift-IR and Shift-DR. The serial output changes only on falling test-clock edges.
- R7: The bypass register captures 0 in Capture-DR and delays serial data by exactly one shift.
- R8: Under EXTEST (3'b000) or SAMPLE/PRELOAD (3'b010), Capture-DR loads the boundary register with these fields for cell i: bit 3i = pin input, bit 3i+1 = core output data, bit 3i+2 = core output enable. Bit 0 is shifted out first and serial input enters bit 3*cells-1.
- R9: SAMPLE/PRELOAD leaves the pins under core control. Values it updates into the boundary update register appear on the pins as soon as EXTEST is loaded.
- R10: Under EXTEST, pin i's data is update bit 3i+1 and its enable is update bit 3i+2, and the output-disable request has no effect.
- R11: Outside EXTEST, pin data follows core data and pin enable is core enable with the output-disable request forcing it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porRst | input | 1 | Synchronous power-on reset, active high |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling edges |
| tdoEn | output | 1 | High when tdo carries valid shift data |
| globalHiZ | input | 1 | Device-wide request to disable all pin drivers |
| coreOut | input | NUM_CELLS | Output data from the core logic |
| coreOe | input | NUM_CELLS | Output enables from the core logic |
| pinIn | input | NUM_CELLS | Values present on the pins |
| pinOut | output | NUM_CELLS | Data driven towards the pins |
| pinOe | output | NUM_CELLS | Pin driver enables |

## Verification
The bench builds the block with NUM_CELLS = 3, which gives a nine-bit boundary chain. At that size each cell's three fields can carry distinct values in one vector. The whole chain also fits in a scan short enough to run for every instruction, including undefined opcodes. The same scans cover the capture layout, preload followed by external test, and the five-clock return to reset from inside Shift-DR.

// File: rtl/scanTapPkg.sv
package scanTapPkg;

  localparam int IR_W = 3;
  localparam int CELL_BITS = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    stReset, stIdle,
    stSelDr, stCapDr, stShfDr, stEx1Dr, stPauDr, stEx2Dr, stUpdDr,
    stSelIr, stCapIr, stShfIr, stEx1Ir, stPauIr, stEx2Ir, stUpdIr
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shfIr;
    logic updIr;
    logic capDr;
    logic shfDr;
    logic updDr;
  } tapStrobe_t;

endpackage

// File: rtl/scanTapCtrl.sv
module scanTapCtrl
  import scanTapPkg::*;
(
  input  logic       tck,
  input  logic       porRst,
  input  logic       tms,
  output tapState_e  stateQ,
  output tapStrobe_t strobe
);

  tapState_e stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      stReset: stateNext = tms ? stReset : stIdle;
      stIdle:  stateNext = tms ? stSelDr : stIdle;
      stSelDr: stateNext = tms ? stSelIr : stCapDr;
      stCapDr: stateNext = tms ? stEx1Dr : stShfDr;
      stShfDr: stateNext = tms ? stEx1Dr : stShfDr;
      stEx1Dr: stateNext = tms ? stUpdDr : stPauDr;
      stPauDr: stateNext = tms ? stEx2Dr : stPauDr;
      stEx2Dr: stateNext = tms ? stUpdDr : stShfDr;
      stUpdDr: stateNext = tms ? stSelDr : stIdle;
      stSelIr: stateNext = tms ? stReset : stCapIr;
      stCapIr: stateNext = tms ? stEx1Ir : stShfIr;
      stShfIr: stateNext = tms ? stEx1Ir : stShfIr;
      stEx1Ir: stateNext = tms ? stUpdIr : stPauIr;
      stPauIr: stateNext = tms ? stEx2Ir : stPauIr;
      stEx2Ir: stateNext = tms ? stUpdIr : stShfIr;
      stUpdIr: stateNext = tms ? stSelDr : stIdle;
      default: stateNext = stReset;
    endcase
  end

  always_ff @(posedge tck) begin
    if (porRst) stateQ <= stReset;
    else        stateQ <= stateNext;
  end

  always_comb begin
    strobe         = '0;
    strobe.inReset = (stateQ == stReset);
    strobe.capIr   = (stateQ == stCapIr);
    strobe.shfIr   = (stateQ == stShfIr);
    strobe.updIr   = (stateQ == stUpdIr);
    strobe.capDr   = (stateQ == stCapDr);
    strobe.shfDr   = (stateQ == stShfDr);
    strobe.updDr   = (stateQ == stUpdDr);
  end

endmodule

// File: rtl/scanTapPath.sv
module scanTapPath
  import scanTapPkg::*;
#(
  parameter int NUM_CELLS = 3
) (
  input  logic                 tck,
  input  logic                 porRst,
  input  logic                 tdi,
  input  tapStrobe_t           strobe,
  input  logic                 globalHiZ,
  input  logic [NUM_CELLS-1:0] coreOut,
  input  logic [NUM_CELLS-1:0] coreOe,
  input  logic [NUM_CELLS-1:0] pinIn,
  output logic [NUM_CELLS-1:0] pinOut,
  output logic [NUM_CELLS-1:0] pinOe,
  output logic                 tdo,
  output logic                 tdoEn,
  output logic [IR_W-1:0]      irQ,
  output logic [NUM_CELLS*CELL_BITS-1:0] bsUpd
);

  localparam int BS_LEN = NUM_CELLS * CELL_BITS;

  logic [IR_W-1:0]   irShift;
  logic              bypassQ;
  logic [BS_LEN-1:0] bsShift;
  logic [BS_LEN-1:0] bsCapture;
  logic              selBoundary;
  logic              extestOn;
  logic              tdoNext;

  assign extestOn    = (irQ == OP_EXTEST);
  assign selBoundary = extestOn || (irQ == OP_SAMPLE);

  // Instruction shift stage, rising edge
  always_ff @(posedge tck) begin
    if (porRst)            irShift <= IR_CAPTURE;
    else if (strobe.capIr) irShift <= IR_CAPTURE;
    else if (strobe.shfIr) irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Active instruction, falling edge
  always_ff @(negedge tck) begin
    if (porRst || strobe.inReset) irQ <= OP_BYPASS;
    else if (strobe.updIr)        irQ <= irShift;
  end

  // Single-bit bypass path
  always_ff @(posedge tck) begin
    if (porRst)            bypassQ <= 1'b0;
    else if (strobe.capDr) bypassQ <= 1'b0;
    else if (strobe.shfDr) bypassQ <= tdi;
  end

  // Per-cell capture fields and pin multiplexers
  for (genvar c = 0; c < NUM_CELLS; c++) begin : gCell
    localparam int BASE = c * CELL_BITS;
    assign bsCapture[BASE]     = pinIn[c];
    assign bsCapture[BASE + 1] = coreOut[c];
    assign bsCapture[BASE + 2] = coreOe[c];

    always_comb begin
      if (extestOn) begin
        pinOut[c] = bsUpd[BASE + 1];
        pinOe[c]  = bsUpd[BASE + 2];
      end else begin
        pinOut[c] = coreOut[c];
        pinOe[c]  = coreOe[c] & ~globalHiZ;
      end
    end
  end

  // Boundary shift stage, rising edge
  always_ff @(posedge tck) begin
    if (porRst) begin
      bsShift <= '0;
    end else if (selBoundary) begin
      if (strobe.capDr)      bsShift <= bsCapture;
      else if (strobe.shfDr) bsShift <= {tdi, bsShift[BS_LEN-1:1]};
    end
  end

  // Boundary update stage, falling edge
  always_ff @(negedge tck) begin
    if (porRst)                           bsUpd <= '0;
    else if (strobe.updDr && selBoundary) bsUpd <= bsShift;
  end

  // Serial output selection
  always_comb begin
    if (strobe.shfIr)     tdoNext = irShift[0];
    else if (selBoundary) tdoNext = bsShift[0];
    else                  tdoNext = bypassQ;
  end

  always_ff @(negedge tck) begin
    if (porRst) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shfIr | strobe.shfDr;
      if (strobe.shfIr | strobe.shfDr) tdo <= tdoNext;
    end
  end

endmodule

// File: rtl/scanTapTop.sv
module scanTapTop
  import scanTapPkg::*;
#(
  parameter int NUM_CELLS = 3
) (
  input  logic                 tck,
  input  logic                 porRst,
  input  logic                 tms,
  input  logic                 tdi,
  output logic                 tdo,
  output logic                 tdoEn,
  input  logic                 globalHiZ,
  input  logic [NUM_CELLS-1:0] coreOut,
  input  logic [NUM_CELLS-1:0] coreOe,
  input  logic [NUM_CELLS-1:0] pinIn,
  output logic [NUM_CELLS-1:0] pinOut,
  output logic [NUM_CELLS-1:0] pinOe
);

  tapState_e  stateQ;
  tapStrobe_t strobe;
  logic [IR_W-1:0] irQ;
  logic [NUM_CELLS*CELL_BITS-1:0] bsUpd;

  scanTapCtrl uCtrl (
    .tck    (tck),
    .porRst (porRst),
    .tms    (tms),
    .stateQ (stateQ),
    .strobe (strobe)
  );

  scanTapPath #(.NUM_CELLS(NUM_CELLS)) uPath (
    .tck       (tck),
    .porRst    (porRst),
    .tdi       (tdi),
    .strobe    (strobe),
    .globalHiZ (globalHiZ),
    .coreOut   (coreOut),
    .coreOe    (coreOe),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .tdo       (tdo),
    .tdoEn     (tdoEn),
    .irQ       (irQ),
    .bsUpd     (bsUpd)
  );

endmodule

// File: rtl/scanTapChk.sv
module scanTapChk
  import scanTapPkg::*;
#(
  parameter int NUM_CELLS = 3
) (
  input logic                 tck,
  input logic                 porRst,
  input logic                 tms,
  input logic                 tdoEn,
  input logic                 globalHiZ,
  input logic [NUM_CELLS-1:0] pinOut,
  input logic [NUM_CELLS-1:0] pinOe,
  input tapState_e            stateQ,
  input logic [IR_W-1:0]      irQ,
  input logic [NUM_CELLS*CELL_BITS-1:0] bsUpd
);

  logic [2:0] tmsRun;
  logic [NUM_CELLS-1:0] expOut;
  logic [NUM_CELLS-1:0] expOe;

  always_ff @(posedge tck) begin
    if (porRst)         tmsRun <= '0;
    else if (!tms)      tmsRun <= '0;
    else if (tmsRun != 3'd7) tmsRun <= tmsRun + 3'd1;
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : gExp
    assign expOut[c] = bsUpd[c*CELL_BITS + 1];
    assign expOe[c]  = bsUpd[c*CELL_BITS + 2];
  end

  // R1
  tms_five_reset_chk: assert property (@(posedge tck) disable iff (porRst)
    (tmsRun >= 3'd5) |-> (stateQ == stReset));

  // R2
  por_reset_chk: assert property (@(posedge tck)
    porRst |=> (stateQ == stReset));

  // R3
  reset_bypass_chk: assert property (@(posedge tck) disable iff (porRst)
    (stateQ == stReset) |=> (irQ == OP_BYPASS));

  // R6
  tdo_enable_chk: assert property (@(posedge tck) disable iff (porRst)
    !(stateQ == stShfDr || stateQ == stShfIr) |-> !tdoEn);

  // R10
  extest_drive_chk: assert property (@(posedge tck) disable iff (porRst)
    (irQ == OP_EXTEST) |-> (pinOut == expOut && pinOe == expOe));

  // R11
  global_hiz_chk: assert property (@(posedge tck) disable iff (porRst)
    (irQ != OP_EXTEST && globalHiZ) |-> (pinOe == '0));

endmodule

bind scanTapTop scanTapChk #(.NUM_CELLS(NUM_CELLS)) uChk (
  .tck       (tck),
  .porRst    (porRst),
  .tms       (tms),
  .tdoEn     (tdoEn),
  .globalHiZ (globalHiZ),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .stateQ    (stateQ),
  .irQ       (irQ),
  .bsUpd     (bsUpd)
);

// File: tb/sim_scanTapTop.sv
`timescale 1ns/1ps
module sim_scanTapTop;

  localparam int NC = 3;
  localparam int BL = 3 * NC;

  logic tck = 1'b0;
  logic porRst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn;
  logic globalHiZ = 1'b0;
  logic [NC-1:0] coreOut = '0, coreOe = '0, pinIn = '0;
  logic [NC-1:0] pinOut, pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 tck = ~tck;

  scanTapTop #(.NUM_CELLS(NC)) u0 (
    .tck(tck), .porRst(porRst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .globalHiZ(globalHiZ), .coreOut(coreOut), .coreOe(coreOe), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // op[21:19] pinIn[18:16] coreOut[15:13] coreOe[12:10] hiZ[9] din[8:0]
  localparam logic [21:0] VEC [6] = '{
    {3'b010, 3'b101, 3'b011, 3'b110, 1'b0, 9'h1A5},
    {3'b000, 3'b010, 3'b100, 3'b111, 1'b1, 9'h0F3},
    {3'b111, 3'b001, 3'b111, 3'b101, 1'b1, 9'h155},
    {3'b101, 3'b110, 3'b010, 3'b011, 1'b0, 9'h0AA},
    {3'b010, 3'b111, 3'b000, 3'b111, 1'b1, 9'h1C7},
    {3'b001, 3'b011, 3'b101, 3'b110, 1'b0, 9'h03C}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic scanDr(input int len, input logic [15:0] din, output logic [15:0] dout, output bit enOk);
    dout = '0;
    enOk = 1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    dout[0] = tdo;
    if (tdoEn !== 1'b1) enOk = 0;
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i]);
      if (i < len - 1) begin
        dout[i+1] = tdo;
        if (tdoEn !== 1'b1) enOk = 0;
      end
    end
    if (tdoEn !== 1'b0) enOk = 0;
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanIr(input logic [2:0] op, output logic [2:0] dout);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    dout[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i]);
      if (i < 2) dout[i+1] = tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  function automatic logic [8:0] capVec(input logic [2:0] pi, input logic [2:0] co, input logic [2:0] ce);
    logic [8:0] v;
    for (int c = 0; c < NC; c++) begin
      v[3*c] = pi[c]; v[3*c+1] = co[c]; v[3*c+2] = ce[c];
    end
    return v;
  endfunction

  function automatic logic [5:0] pinsExp(input logic [2:0] op, input logic [2:0] co, input logic [2:0] ce,
                                         input logic hz, input logic [8:0] upd);
    logic [2:0] o, e;
    for (int c = 0; c < NC; c++) begin
      if (op == 3'b000) begin o[c] = upd[3*c+1]; e[c] = upd[3*c+2]; end
      else begin o[c] = co[c]; e[c] = ce[c] & ~hz; end
    end
    return {e, o};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] dout;
    logic [2:0] irOut;
    logic [8:0] upd;
    logic [15:0] expOut;
    bit enOk;
    logic held;

    coreOut = 3'b101; coreOe = 3'b011; globalHiZ = 1'b0;
    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    porRst = 1'b0;
    // R2: reset state
    check(tdoEn === 1'b0, "R2 tdoEn after reset", tdoEn, 0);
    check({pinOe, pinOut} === {coreOe, coreOut}, "R2 pins follow core after reset", {pinOe, pinOut}, {coreOe, coreOut});
    tick(0, 0);

    // R7: bypass after reset, one-shift delay with captured 0
    scanDr(8, 16'h00B5, dout, enOk);
    check(dout[7:0] === 8'h6A, "R7 bypass delay", dout[7:0], 8'h6A);
    // R6: enable only while shifting
    check(enOk, "R6 tdoEn during and after shift", enOk, 1);

    // R4: IR capture pattern, lsb first
    scanIr(3'b111, irOut);
    check(irOut === 3'b001, "R4 IR capture", irOut, 3'b001);

    // Vector table: R8 R9 R10 R11 R3 R7
    upd = '0;
    for (int k = 0; k < 6; k++) begin
      logic [2:0] op, pi, co, ce;
      logic hz;
      logic [8:0] din;
      {op, pi, co, ce, hz, din} = VEC[k];
      pinIn = pi; coreOut = co; coreOe = ce; globalHiZ = hz;
      scanIr(op, irOut);
      scanDr(BL, {7'b0, din}, dout, enOk);
      if (op == 3'b000 || op == 3'b010) begin
        expOut = {7'b0, capVec(pi, co, ce)};
        upd = din;
      end else begin
        expOut = {7'b0, din[7:0], 1'b0};
      end
      check(dout[8:0] === expOut[8:0], $sformatf("R8/R7/R3 scan row %0d", k), dout[8:0], expOut[8:0]);
      check({pinOe, pinOut} === pinsExp(op, co, ce, hz, upd),
            $sformatf("R10/R11/R9 pins row %0d", k), {pinOe, pinOut}, pinsExp(op, co, ce, hz, upd));
    end

    // R9: preload then EXTEST drives preloaded values at once
    coreOut = 3'b000; coreOe = 3'b000; globalHiZ = 1'b1;
    scanIr(3'b010, irOut);
    scanDr(BL, 16'h00B6, dout, enOk);
    check({pinOe, pinOut} === 6'b000000, "R9 sample leaves pins on core", {pinOe, pinOut}, 0);
    scanIr(3'b000, irOut);
    check({pinOe, pinOut} === pinsExp(3'b000, 3'b0, 3'b0, 1'b1, 9'h0B6), "R9 preload on EXTEST",
          {pinOe, pinOut}, pinsExp(3'b000, 3'b0, 3'b0, 1'b1, 9'h0B6));

    // R5: while shifting a new instruction, EXTEST keeps the pins
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 1);
    check({pinOe, pinOut} === pinsExp(3'b000, 3'b0, 3'b0, 1'b1, 9'h0B6), "R5 old IR during shift",
          {pinOe, pinOut}, pinsExp(3'b000, 3'b0, 3'b0, 1'b1, 9'h0B6));
    // R6: tdo does not move on the rising edge
    held = tdo;
    tms = 1'b1; tdi = 1'b1;
    @(posedge tck); #0.5;
    check(tdo === held, "R6 tdo stable at rising edge", tdo, held);
    @(negedge tck); #1;
    tick(1, 0);
    check({pinOe, pinOut} === 6'b000000, "R5 new IR after Update-IR", {pinOe, pinOut}, 0);
    tick(0, 0);

    // R1: five TMS-high clocks from Shift-DR under EXTEST
    scanIr(3'b000, irOut);
    coreOut = 3'b110; coreOe = 3'b111; globalHiZ = 1'b0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    check(tdoEn === 1'b0, "R1 tdoEn after five TMS high", tdoEn, 0);
    check({pinOe, pinOut} === {coreOe, coreOut}, "R1 pins back to core", {pinOe, pinOut}, {coreOe, coreOut});
    tick(0, 0);
    scanDr(4, 16'h000D, dout, enOk);
    check(dout[3:0] === 4'hA, "R1 bypass after TMS reset", dout[3:0], 4'hA);

    // R2: power-on reset in mid-scan
    scanIr(3'b000, irOut);
    tick(1, 0); tick(0, 0); tick(0, 0);
    tms = 1'b0; porRst = 1'b1;
    @(posedge tck); @(negedge tck); #1;
    porRst = 1'b0;
    check(tdoEn === 1'b0, "R2 tdoEn after POR", tdoEn, 0);
    check({pinOe, pinOut} === {coreOe, coreOut}, "R2 pins after POR", {pinOe, pinOut}, {coreOe, coreOut});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule